// File: doc/BRIEF.md
# Ordered-List LRU Replacement Tracker

This block records, for every set of a set-associative cache, the exact recency order of that set's ways. Each set stores a list that holds every way index once. Position 0 of the list is the most recently used way and the final position is the least recently used way. The cache controller pulses an update strobe once per access. The strobe carries the set index, a hit flag and, on a hit, the way that matched. The block then rewrites that set's list.

A separate query port reads any set's full list and its replacement candidate without a clock delay. The controller reads the candidate for the set it is about to fill on a miss. Tag matching, line data and memory traffic are handled elsewhere.

Top module: `lru_order_tracker`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, every set's list is (0, 1, ..., NUM_WAYS-1), with way 0 in position 0.
- R2: `victim_way` is combinational and always equals the way in the last position of the list of the set selected by `query_set`.
- R3: An update with `upd_hit`=1 moves `upd_way` to position 0. Every way that was ahead of it moves back by one position, and every way that was behind it stays where it was.
- R4: An update with `upd_hit`=0 moves the way from the last position to position 0, and every other way moves back by one position. `upd_way` is ignored.
- R5: A hit on the way already in position 0 leaves that set's list unchanged.
- R6: A set's list changes only on a clock edge where `upd_valid`=1 and `upd_set` selects that set. Without the strobe, every list holds.
- R7: Every list always contains each way index from 0 to NUM_WAYS-1 exactly once.
- R8: `query_order` packs the list of the set selected by `query_set`. Position k occupies bits [k*W +: W], where W = max(1, clog2(NUM_WAYS)). Position 0 is the most recently used way.
- R9: With NUM_WAYS=4, starting from (0,1,2,3), the sequence hit way 2, hit way 1, miss, hit way 3 yields (2,0,1,3), then (1,2,0,3), then (3,1,2,0), then (3,1,2,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid | input | 1 | Access strobe; applies one update this cycle |
| upd_set | input | SW = max(1, clog2(NUM_SETS)) | Set addressed by the update |
| upd_hit | input | 1 | 1 = hit on `upd_way`, 0 = miss (fill the victim) |
| upd_way | input | W | Way that hit; ignored on a miss |
| query_set | input | SW | Set whose list is read out |
| query_order | output | NUM_WAYS*W | Recency list of `query_set`, MRU in the lowest field |
| victim_way | output | W | Least recently used way of `query_set` |

## Verification
Some properties are checked on every cycle. Each observed list must be a permutation, and an idle cycle or an update to another set must leave the observed list unchanged. After a hit or a miss on the observed set, the correct way must appear in position 0 on the next cycle. A MRU hit must leave the list frozen, and the list after reset must have the identity victim. Some behaviour only the bench's scenarios can show. These are the exact shift pattern of the ways behind and ahead of a promoted way, the literal four-way sequence, and long mixed streams over many sets. The bench compares these against its queue-based model on every clock.

// File: rtl/lru_pkg.sv
// Package lru_pkg
// Shared helpers for the recency tracker: width of a way index.
// Assumes a way count of at least one.
package lru_pkg;

    // Bits needed to name one of n items, never less than one.
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lru_reorder.sv
// Module lru_reorder
// Purely combinational. Takes one set's recency list and produces the list
// after a hit or a miss. The promoted way goes to position 0, and the
// entries between position 0 and the promoted way's old position slide back
// by one place. Assumes the incoming list is a permutation. If a hit names
// a way that is absent, the list is returned unchanged.
module lru_reorder #(
    parameter int NUM_WAYS = 4,
    parameter int WW       = lru_pkg::idx_bits(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WW-1:0] cur_list,
    input  logic                   hit,
    input  logic [WW-1:0]          hit_way,
    output logic [NUM_WAYS*WW-1:0] new_list
);

    localparam int LAST = NUM_WAYS - 1;

    int          hit_pos;
    logic        found;
    int          move_pos;
    logic [WW-1:0] promote;

    // Locate the hit way inside the current list.
    always_comb begin
        hit_pos = 0;
        found   = 1'b0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (!found && cur_list[i*WW +: WW] == hit_way) begin
                hit_pos = i;
                found   = 1'b1;
            end
        end
    end

    // Choose which way is promoted and from which position.
    always_comb begin
        if (hit) begin
            move_pos = found ? hit_pos : 0;
            promote  = found ? hit_way : cur_list[0 +: WW];
        end else begin
            move_pos = LAST;
            promote  = cur_list[LAST*WW +: WW];
        end
    end

    // Rebuild the list: the promoted way in front, then a one-place shift up to move_pos.
    always_comb begin
        new_list         = cur_list;
        new_list[0 +: WW] = promote;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (i <= move_pos)
                new_list[i*WW +: WW] = cur_list[(i-1)*WW +: WW];
        end
    end

endmodule

// File: rtl/lru_set_store.sv
// Module lru_set_store
// Register array holding one packed recency list per set. It has one
// synchronous write port and two combinational read ports: one for the
// update path and one for the query path. A synchronous active-low reset
// loads the identity list (0, 1, ..., NUM_WAYS-1) into every set.
module lru_set_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int WW       = lru_pkg::idx_bits(NUM_WAYS),
    parameter int SW       = lru_pkg::idx_bits(NUM_SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SW-1:0]          wr_set,
    input  logic [NUM_WAYS*WW-1:0] wr_list,
    input  logic [SW-1:0]          rd_set_a,
    output logic [NUM_WAYS*WW-1:0] rd_list_a,
    input  logic [SW-1:0]          rd_set_b,
    output logic [NUM_WAYS*WW-1:0] rd_list_b
);

    localparam int LW = NUM_WAYS * WW;

    logic [LW-1:0] lists [NUM_SETS];
    logic [LW-1:0] ident;

    // Identity ordering used at reset.
    generate
        for (genvar k = 0; k < NUM_WAYS; k++) begin : g_ident
            assign ident[k*WW +: WW] = WW'(k);
        end
    endgenerate

    // Reset all sets, or store the rewritten list of the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                lists[s] <= ident;
        end else if (wr_en) begin
            lists[wr_set] <= wr_list;
        end
    end

    // Combinational reads for update and query.
    assign rd_list_a = lists[rd_set_a];
    assign rd_list_b = lists[rd_set_b];

endmodule

// File: rtl/lru_order_tracker.sv
// Module lru_order_tracker (top)
// True LRU tracker that keeps an explicit ordered way list per set. On each
// strobe it reads the addressed set, reorders it through lru_reorder and
// writes it back in the same cycle. The query port and the victim output
// read the store combinationally. Assumes at most one access per cycle and
// an upd_set value below NUM_SETS.
module lru_order_tracker #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WW      = lru_pkg::idx_bits(NUM_WAYS),
    localparam int SW      = lru_pkg::idx_bits(NUM_SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_valid,
    input  logic [SW-1:0]          upd_set,
    input  logic                   upd_hit,
    input  logic [WW-1:0]          upd_way,
    input  logic [SW-1:0]          query_set,
    output logic [NUM_WAYS*WW-1:0] query_order,
    output logic [WW-1:0]          victim_way
);

    localparam int LW = NUM_WAYS * WW;

    logic [LW-1:0] upd_cur;
    logic [LW-1:0] upd_next;

    // Per-set list storage.
    lru_set_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .WW       (WW),
        .SW       (SW)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (upd_valid),
        .wr_set    (upd_set),
        .wr_list   (upd_next),
        .rd_set_a  (upd_set),
        .rd_list_a (upd_cur),
        .rd_set_b  (query_set),
        .rd_list_b (query_order)
    );

    // Reordering of the addressed set's list.
    lru_reorder #(
        .NUM_WAYS (NUM_WAYS),
        .WW       (WW)
    ) reorder_i (
        .cur_list (upd_cur),
        .hit      (upd_hit),
        .hit_way  (upd_way),
        .new_list (upd_next)
    );

    // The victim is the tail entry of the queried list.
    assign victim_way = query_order[(NUM_WAYS-1)*WW +: WW];

endmodule

// File: rtl/lru_order_checker.sv
// Module lru_order_checker
// Property checker attached to lru_order_tracker. It observes the query
// port only, and relates it to the update strobe across clock edges.
module lru_order_checker #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WW      = lru_pkg::idx_bits(NUM_WAYS),
    localparam int SW      = lru_pkg::idx_bits(NUM_SETS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   upd_valid,
    input logic [SW-1:0]          upd_set,
    input logic                   upd_hit,
    input logic [WW-1:0]          upd_way,
    input logic [SW-1:0]          query_set,
    input logic [NUM_WAYS*WW-1:0] query_order,
    input logic [WW-1:0]          victim_way
);

    logic [(1<<WW)-1:0] seen;
    logic [WW-1:0]      head;

    // Mark which way indices occur in the observed list.
    always_comb begin
        seen = '0;
        for (int i = 0; i < NUM_WAYS; i++)
            seen[query_order[i*WW +: WW]] = 1'b1;
    end

    assign head = query_order[0 +: WW];

    // R1: one cycle after reset, the victim is the highest way index.
    p_reset_identity_r1: assert property (@(posedge clk)
        !rst_n |=> victim_way == WW'(NUM_WAYS-1));

    // R7: the observed list is a permutation of all ways.
    p_permutation_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NUM_WAYS);

    // R3: a hit on the observed set puts the hit way in front.
    p_hit_front_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit && upd_set == query_set)
        |=> (query_set != $past(query_set)) || (head == $past(upd_way)));

    // R4: a miss on the observed set puts the old victim in front.
    p_miss_front_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_hit && upd_set == query_set)
        |=> (query_set != $past(query_set)) || (head == $past(victim_way)));

    // R5: a hit on the current MRU way leaves the list frozen.
    p_mru_hit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit && upd_set == query_set && upd_way == head)
        |=> (query_set != $past(query_set)) || $stable(query_order));

    // R6: no strobe, or a strobe to another set, leaves the observed list as it was.
    p_untouched_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || upd_set != query_set)
        |=> (query_set != $past(query_set)) || $stable(query_order));

endmodule

bind lru_order_tracker lru_order_checker #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_valid   (upd_valid),
    .upd_set     (upd_set),
    .upd_hit     (upd_hit),
    .upd_way     (upd_way),
    .query_set   (query_set),
    .query_order (query_order),
    .victim_way  (victim_way)
);

// File: tb/lru_order_tracker_tb_top.sv
`timescale 1ns/1ps
// Bench for lru_order_tracker. A queue-per-set reference model is updated
// at every clock edge, and the query port is compared against it every cycle.
module lru_order_tracker_tb_top;

    localparam int NUM_WAYS = 4;
    localparam int NUM_SETS = 16;
    localparam int WW = lru_pkg::idx_bits(NUM_WAYS);
    localparam int SW = lru_pkg::idx_bits(NUM_SETS);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   upd_valid = 1'b0;
    logic [SW-1:0]          upd_set = '0;
    logic                   upd_hit = 1'b0;
    logic [WW-1:0]          upd_way = '0;
    logic [SW-1:0]          query_set = '0;
    logic [NUM_WAYS*WW-1:0] query_order;
    logic [WW-1:0]          victim_way;

    int n_checks = 0;
    int n_fails  = 0;
    int model [NUM_SETS][$];
    string prev_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    lru_order_tracker #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_set(upd_set),
        .upd_hit(upd_hit), .upd_way(upd_way), .query_set(query_set),
        .query_order(query_order), .victim_way(victim_way)
    );

    always #2 clk = ~clk;

    function automatic string list_str(input logic [NUM_WAYS*WW-1:0] v);
        string s = "(";
        for (int k = 0; k < NUM_WAYS; k++)
            s = {s, $sformatf("%0d%s", v[k*WW +: WW], (k == NUM_WAYS-1) ? ")" : ",")};
        return s;
    endfunction

    function automatic logic [NUM_WAYS*WW-1:0] model_vec(input int s);
        logic [NUM_WAYS*WW-1:0] v = '0;
        for (int k = 0; k < NUM_WAYS; k++)
            v[k*WW +: WW] = WW'(model[s][k]);
        return v;
    endfunction

    // Compare list (R8 packing), victim (R2) and permutation (R7) with the model.
    task automatic check_model(input string tag);
        logic [NUM_WAYS*WW-1:0] exp_v;
        int cnt [NUM_WAYS];
        logic perm_ok;
        exp_v = model_vec(int'(query_set));
        n_checks++;
        if (query_order !== exp_v) begin
            n_fails++;
            $display("FAIL %s/R8 set %0d order actual %s expected %s", tag, query_set,
                     list_str(query_order), list_str(exp_v));
        end
        n_checks++;
        if (victim_way !== exp_v[(NUM_WAYS-1)*WW +: WW]) begin
            n_fails++;
            $display("FAIL R2 set %0d victim actual %0d expected %0d", query_set,
                     victim_way, exp_v[(NUM_WAYS-1)*WW +: WW]);
        end
        foreach (cnt[k]) cnt[k] = 0;
        for (int k = 0; k < NUM_WAYS; k++)
            if (int'(query_order[k*WW +: WW]) < NUM_WAYS) cnt[query_order[k*WW +: WW]]++;
        perm_ok = 1'b1;
        foreach (cnt[k]) if (cnt[k] != 1) perm_ok = 1'b0;
        n_checks++;
        if (!perm_ok) begin
            n_fails++;
            $display("FAIL R7 set %0d list actual %s expected a permutation", query_set,
                     list_str(query_order));
        end
    endtask

    // One clock: drive at negedge, check pre-edge state, then update the model at the edge.
    task automatic cycle(input logic v, input int s, input logic h, input int w,
                         input int q, input string tag);
        upd_valid = v; upd_set = SW'(s); upd_hit = h; upd_way = WW'(w); query_set = SW'(q);
        #0.5;
        check_model(prev_tag);
        prev_tag = tag;
        @(posedge clk);
        if (v) begin
            if (h) begin
                foreach (model[s][k]) if (model[s][k] == w) begin
                    model[s].delete(k);
                    break;
                end
                model[s].push_front(w);
            end else begin
                model[s].push_front(model[s].pop_back());
            end
        end
        @(negedge clk);
    endtask

    // Literal expectation for a four-way list (R9).
    task automatic expect4(input int s, input int e0, input int e1, input int e2,
                           input int e3, input string tag);
        logic [NUM_WAYS*WW-1:0] exp_v;
        upd_valid = 1'b0; query_set = SW'(s);
        exp_v = {WW'(e3), WW'(e2), WW'(e1), WW'(e0)};
        #0.5;
        n_checks++;
        if (query_order !== exp_v) begin
            n_fails++;
            $display("FAIL %s set %0d actual %s expected %s", tag, s,
                     list_str(query_order), list_str(exp_v));
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        for (int s = 0; s < NUM_SETS; s++) begin
            model[s].delete();
            for (int w = 0; w < NUM_WAYS; w++) model[s].push_back(w);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every set holds the identity list after reset (idle sweep, also R6).
        for (int s = 0; s < NUM_SETS; s++) cycle(1'b0, 0, 1'b0, 0, s, "R1");
        expect4(0, 0, 1, 2, 3, "R1");

        // R9 / R3 / R4 / R5: the literal sequence on set 3.
        cycle(1'b1, 3, 1'b1, 2, 3, "R3");
        expect4(3, 2, 0, 1, 3, "R9");
        cycle(1'b1, 3, 1'b1, 1, 3, "R3");
        expect4(3, 1, 2, 0, 3, "R9");
        cycle(1'b1, 3, 1'b0, 1, 3, "R4");
        expect4(3, 3, 1, 2, 0, "R9");
        cycle(1'b1, 3, 1'b1, 3, 3, "R5");
        expect4(3, 3, 1, 2, 0, "R5");

        // R4: repeated misses rotate the list; upd_way is driven but ignored.
        for (int i = 0; i < 5; i++) cycle(1'b1, NUM_SETS-1, 1'b0, i % NUM_WAYS, NUM_SETS-1, "R4");
        // R3: hit on the LRU way and on a middle way of set 0.
        cycle(1'b1, 0, 1'b1, 3, 0, "R3");
        cycle(1'b1, 0, 1'b1, 1, 0, "R3");
        // R6: updates to set 0 while set 3 is observed must not touch set 3.
        cycle(1'b1, 0, 1'b0, 0, 3, "R6");
        cycle(1'b1, 0, 1'b1, 2, 3, "R6");
        expect4(3, 3, 1, 2, 0, "R6");
        // R6: idle cycles hold the list.
        for (int i = 0; i < 4; i++) cycle(1'b0, 0, 1'b1, i, 0, "R6");

        // Mixed stream across all sets; query follows the updated set or wanders.
        for (int i = 0; i < 600; i++) begin
            int s, q;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[3:0]) % NUM_SETS;
            q = lfsr[9] ? s : int'(lfsr[13:10]) % NUM_SETS;
            cycle(lfsr[4] | lfsr[5], s, lfsr[6], int'(lfsr[8:7]) % NUM_WAYS, q,
                  lfsr[6] ? "R3" : "R4");
        end

        // Final sweep of every set against the model (R6 idle, R7, R8).
        for (int s = 0; s < NUM_SETS; s++) cycle(1'b0, 0, 1'b0, 0, s, "R6");
        cycle(1'b0, 0, 1'b0, 0, 0, "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule